// File: doc/BRIEF.md
# Reservation Buffer Slot Tracker

This block keeps the occupancy and hold state for a small set of processor resources, each of which may own a reservation buffer. Every resource is configured at elaboration by a signed buffer size. A negative size gives a resource whose buffer never fills. A size of zero gives a dispatch hazard that stays held from dispatch until software-visible strobes release it. A size of one gives a single-entry unit that forces in-order execution. Any larger size gives an ordinary buffered resource with that many slots.

Each resource takes four one-cycle strobes: take a slot, give a slot back, set the hold flag and clear the hold flag. From these it reports a two-bit availability code and its count of free slots. A combined dispatch check looks at any chosen subset of resources through a mask. It reports available only when every selected resource is available. Otherwise it reports the code of the lowest-numbered selected resource that blocks dispatch.

Top module: `slot_tracker_top`

## Requirements
- R1: After reset, every buffered resource reports a free count equal to its buffer size, every other resource reports zero, every hold flag is clear and every status code is available.
- R2: A resource configured with size -1 always reports a free count of zero and status available; take and give strobes have no effect on it.
- R3: For a size-0 resource, a take strobe sets its hold flag; while the flag is set its status is reserved, and a clear strobe returns it to available. Its free count stays zero.
- R4: Status codes are 2'b00 available, 2'b01 unavailable, 2'b10 reserved; a buffered resource whose free count is zero reports unavailable.
- R5: A take strobe on its own decrements a buffered resource's free count by one in the next cycle only when the count is nonzero; at zero the count stays zero.
- R6: A give strobe on its own increments the free count only for buffered resources and never past the buffer size.
- R7: Take and give strobes in the same cycle leave the free count unchanged.
- R8: The set strobe sets the hold flag; the clear strobe clears it; when set (or a hazard take) and clear arrive together, the flag ends up set. Outside the hazard mode the flag does not change the status.
- R9: The error output bit of a resource is high, in the same cycle, when its set strobe arrives while its hold flag is already set.
- R10: The dispatch check returns 2'b00 when no resource selected by the mask is unavailable or reserved; otherwise it returns the status code of the lowest-indexed selected resource that is not available. An empty mask returns 2'b00.
- R11: A size-1 resource becomes unavailable after one take and available again after one give.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| take_i | input | NUM_RES | Per-resource take-slot strobe |
| give_i | input | NUM_RES | Per-resource give-slot strobe |
| hold_set_i | input | NUM_RES | Per-resource set-hold strobe |
| hold_clr_i | input | NUM_RES | Per-resource clear-hold strobe |
| sel_mask_i | input | NUM_RES | Resources included in the dispatch check |
| status_o | output | 2*NUM_RES | Status code of resource i at bits [2i+1:2i] |
| free_o | output | NUM_RES*CNT_W | Free-slot count of resource i at bits [i*CNT_W +: CNT_W] |
| dispatch_o | output | 2 | Combined dispatch check code |
| hold_err_o | output | NUM_RES | Set strobe seen while hold flag already set |

## Verification
The in-line assertions watch, on every cycle, that a free count stays within its buffer size, that a lone take moves the count down by one or holds it at zero, that simultaneous take and give leave it alone, that a hazard take or set strobe leaves the hold flag set, and that the dispatch code agrees with the individual status codes under the mask. The bench scenarios are needed to show the exact codes and counts after specific sequences, the same-cycle error pulse, the set-wins-over-clear ordering seen through a later error, the lowest-index priority of the dispatch check, and the return to reset values after a reset taken in mid-run.

// File: rtl/slot_tracker_pkg.sv
package slot_tracker_pkg;

  typedef enum logic [1:0] {
    ST_AVAIL   = 2'b00,
    ST_FULL    = 2'b01,
    ST_HELD    = 2'b10
  } slot_stat_e;

  typedef enum logic [1:0] {
    MODE_ENDLESS  = 2'b00,
    MODE_HAZARD   = 2'b01,
    MODE_INORDER  = 2'b10,
    MODE_BUFFERED = 2'b11
  } buf_mode_e;

  function automatic buf_mode_e mode_of(input int size);
    if (size < 0)       return MODE_ENDLESS;
    else if (size == 0) return MODE_HAZARD;
    else if (size == 1) return MODE_INORDER;
    else                return MODE_BUFFERED;
  endfunction

  function automatic bit has_slots(input buf_mode_e m);
    return (m == MODE_INORDER) || (m == MODE_BUFFERED);
  endfunction

endpackage

// File: rtl/slot_reset_sync.sv
module slot_reset_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= sync_d;
  end

  assign rst_sync_n = sync_q[STAGES-1];
endmodule

// File: rtl/slot_counter.sv
module slot_counter #(
  parameter int CAP   = 3,
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             take_i,
  input  logic             give_i,
  output logic [CNT_W-1:0] cnt_o
);
  localparam logic [CNT_W-1:0] CAP_V = CNT_W'(CAP);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;
  logic             dec;
  logic             inc;
  logic             cnt_en;

  always_comb begin
    dec    = take_i && !give_i && (cnt_q != '0);
    inc    = give_i && !take_i && (cnt_q < CAP_V);
    cnt_en = dec || inc;
    cnt_d  = inc ? (cnt_q + 1'b1) : (cnt_q - 1'b1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= CAP_V;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign cnt_o = cnt_q;

  // R6: count never rises above the buffer size
  a_r6_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CAP_V);

  // R5: a lone take on a nonzero count lowers it by one
  a_r5_take_dec: assert property (@(posedge clk) disable iff (!rst_n)
    (take_i && !give_i && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - 1'b1));

  // R5: a lone take on an empty buffer leaves it empty
  a_r5_take_floor: assert property (@(posedge clk) disable iff (!rst_n)
    (take_i && !give_i && cnt_q == '0) |=> (cnt_q == '0));

  // R7: simultaneous take and give leave the count alone
  a_r7_both_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (take_i && give_i) |=> (cnt_q == $past(cnt_q)));
endmodule

// File: rtl/hold_flag.sv
module hold_flag #(
  parameter bit HAZARD = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  input  logic take_i,
  output logic flag_o,
  output logic err_o
);
  logic flag_q;
  logic flag_d;
  logic flag_en;
  logic set_any;

  always_comb begin
    set_any = set_i || (HAZARD && take_i);
    flag_en = set_any || clr_i;
    flag_d  = set_any || (flag_q && !clr_i);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       flag_q <= 1'b0;
    else if (flag_en) flag_q <= flag_d;
  end

  assign flag_o = flag_q;
  assign err_o  = set_i && flag_q;

  // R8: a set strobe always leaves the flag set, even with clear
  a_r8_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
    set_i |=> flag_q);

  // R8: a lone clear strobe leaves the flag clear
  a_r8_clr_only: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_i && !set_i && !(HAZARD && take_i)) |=> !flag_q);

  // R3: a take on a hazard resource holds it
  a_r3_haz_take: assert property (@(posedge clk) disable iff (!rst_n)
    (HAZARD && take_i) |=> flag_q);
endmodule

// File: rtl/slot_status_enc.sv
module slot_status_enc
  import slot_tracker_pkg::*;
#(
  parameter int CNT_W = 4,
  parameter bit HAZARD = 1'b0,
  parameter bit SLOTTED = 1'b0
) (
  input  logic             flag_i,
  input  logic [CNT_W-1:0] cnt_i,
  output slot_stat_e       status_o
);
  always_comb begin
    if (HAZARD && flag_i)                 status_o = ST_HELD;
    else if (!SLOTTED || (cnt_i != '0))   status_o = ST_AVAIL;
    else                                  status_o = ST_FULL;
  end
endmodule

// File: rtl/slot_tracker.sv
module slot_tracker
  import slot_tracker_pkg::*;
#(
  parameter int SIZE  = 3,
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             take_i,
  input  logic             give_i,
  input  logic             set_i,
  input  logic             clr_i,
  output slot_stat_e       status_o,
  output logic [CNT_W-1:0] free_o,
  output logic             err_o
);
  localparam buf_mode_e MODE    = mode_of(SIZE);
  localparam bit        HAZARD  = (MODE == MODE_HAZARD);
  localparam bit        SLOTTED = has_slots(MODE);

  logic [CNT_W-1:0] cnt;
  logic             flag;

  generate
    if (SLOTTED) begin : g_slots
      slot_counter #(
        .CAP   (SIZE),
        .CNT_W (CNT_W)
      ) u_cnt (
        .clk    (clk),
        .rst_n  (rst_n),
        .take_i (take_i),
        .give_i (give_i),
        .cnt_o  (cnt)
      );
    end else begin : g_noslots
      assign cnt = '0;
    end
  endgenerate

  hold_flag #(
    .HAZARD (HAZARD)
  ) u_flag (
    .clk    (clk),
    .rst_n  (rst_n),
    .set_i  (set_i),
    .clr_i  (clr_i),
    .take_i (take_i),
    .flag_o (flag),
    .err_o  (err_o)
  );

  slot_status_enc #(
    .CNT_W   (CNT_W),
    .HAZARD  (HAZARD),
    .SLOTTED (SLOTTED)
  ) u_enc (
    .flag_i   (flag),
    .cnt_i    (cnt),
    .status_o (status_o)
  );

  assign free_o = cnt;

  // R2: resources without slots always report zero free slots
  a_r2_no_slots_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !SLOTTED |-> (free_o == '0));

  // R4: a slotted resource with no free slot is never reported available
  a_r4_empty_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    (SLOTTED && free_o == '0) |-> (status_o != ST_AVAIL));
endmodule

// File: rtl/dispatch_check.sv
module dispatch_check
  import slot_tracker_pkg::*;
#(
  parameter int NUM_RES = 4
) (
  input  logic [NUM_RES-1:0]   sel_i,
  input  logic [2*NUM_RES-1:0] status_i,
  output slot_stat_e           result_o
);
  always_comb begin
    result_o = ST_AVAIL;
    for (int i = NUM_RES - 1; i >= 0; i--) begin
      if (sel_i[i] && (status_i[2*i +: 2] != ST_AVAIL)) begin
        result_o = slot_stat_e'(status_i[2*i +: 2]);
      end
    end
  end
endmodule

// File: rtl/slot_tracker_top.sv
module slot_tracker_top
  import slot_tracker_pkg::*;
#(
  parameter int NUM_RES = 4,
  parameter int CNT_W   = 4,
  parameter int BUF_SIZE [NUM_RES] = '{-1, 0, 1, 3}
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [NUM_RES-1:0]       take_i,
  input  logic [NUM_RES-1:0]       give_i,
  input  logic [NUM_RES-1:0]       hold_set_i,
  input  logic [NUM_RES-1:0]       hold_clr_i,
  input  logic [NUM_RES-1:0]       sel_mask_i,
  output logic [2*NUM_RES-1:0]     status_o,
  output logic [NUM_RES*CNT_W-1:0] free_o,
  output logic [1:0]               dispatch_o,
  output logic [NUM_RES-1:0]       hold_err_o
);
  logic       rst_sync_n;
  slot_stat_e disp;
  logic [NUM_RES-1:0] blocking;

  slot_reset_sync #(
    .STAGES (2)
  ) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  generate
    for (genvar g = 0; g < NUM_RES; g++) begin : g_res
      slot_stat_e st;
      slot_tracker #(
        .SIZE  (BUF_SIZE[g]),
        .CNT_W (CNT_W)
      ) u_trk (
        .clk      (clk),
        .rst_n    (rst_sync_n),
        .take_i   (take_i[g]),
        .give_i   (give_i[g]),
        .set_i    (hold_set_i[g]),
        .clr_i    (hold_clr_i[g]),
        .status_o (st),
        .free_o   (free_o[g*CNT_W +: CNT_W]),
        .err_o    (hold_err_o[g])
      );
      assign status_o[2*g +: 2] = st;
      assign blocking[g] = (st != ST_AVAIL);
    end
  endgenerate

  dispatch_check #(
    .NUM_RES (NUM_RES)
  ) u_disp (
    .sel_i    (sel_mask_i),
    .status_i (status_o),
    .result_o (disp)
  );

  assign dispatch_o = disp;

  // R10: available result only when no selected resource blocks
  a_r10_avail_clean: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (disp == ST_AVAIL) |-> ((sel_mask_i & blocking) == '0));

  // R10: any selected blocker forces a non-available result
  a_r10_block_seen: assert property (@(posedge clk) disable iff (!rst_sync_n)
    ((sel_mask_i & blocking) != '0) |-> (disp != ST_AVAIL));
endmodule

// File: tb/slot_tracker_top_tb.sv
`timescale 1ns/1ps
module slot_tracker_top_tb;
  localparam int N  = 4;
  localparam int CW = 4;

  logic          clk;
  logic          rst_n;
  logic [N-1:0]  take, give, hset, hclr, mask;
  logic [2*N-1:0]  status;
  logic [N*CW-1:0] free;
  logic [1:0]      disp;
  logic [N-1:0]    err;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;
  bit done   = 0;

  slot_tracker_top #(
    .NUM_RES (N),
    .CNT_W   (CW),
    .BUF_SIZE ('{-1, 0, 1, 3})
  ) u_dut (
    .clk        (clk),
    .rst_n      (rst_n),
    .take_i     (take),
    .give_i     (give),
    .hold_set_i (hset),
    .hold_clr_i (hclr),
    .sel_mask_i (mask),
    .status_o   (status),
    .free_o     (free),
    .dispatch_o (disp),
    .hold_err_o (err)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  typedef struct packed {
    logic [3:0]  tk;
    logic [3:0]  gv;
    logic [3:0]  st;
    logic [3:0]  cl;
    logic [3:0]  mk;
    logic [7:0]  est;
    logic [15:0] efr;
    logic [1:0]  edp;
    logic [3:0]  eer;
  } vec_t;

  // resources: 0 endless(-1), 1 hazard(0), 2 in-order(1), 3 buffered(3)
  localparam vec_t VECS [16] = '{
    '{4'hF, 4'h0, 4'h0, 4'h0, 4'h0, 8'h18, 16'h2000, 2'b00, 4'h0}, // R2 R3 R5 R11
    '{4'h0, 4'h0, 4'h0, 4'h0, 4'hF, 8'h18, 16'h2000, 2'b10, 4'h0}, // R10 lowest blocker held
    '{4'h0, 4'h0, 4'h0, 4'h0, 4'hC, 8'h18, 16'h2000, 2'b01, 4'h0}, // R10 full
    '{4'h8, 4'h4, 4'h0, 4'h2, 4'hF, 8'h00, 16'h1100, 2'b00, 4'h0}, // R3 R11 R10
    '{4'h8, 4'hB, 4'h0, 4'h0, 4'h0, 8'h00, 16'h1100, 2'b00, 4'h0}, // R7 R2 R6
    '{4'h8, 4'h0, 4'h0, 4'h0, 4'h8, 8'h40, 16'h0100, 2'b01, 4'h0}, // R4 R5
    '{4'h8, 4'h0, 4'h0, 4'h0, 4'h8, 8'h40, 16'h0100, 2'b01, 4'h0}, // R5 floor
    '{4'h0, 4'hC, 4'h0, 4'h0, 4'h8, 8'h00, 16'h1100, 2'b00, 4'h0}, // R6 ceiling
    '{4'h0, 4'h0, 4'h8, 4'h0, 4'h0, 8'h00, 16'h1100, 2'b00, 4'h0}, // R8 set
    '{4'h0, 4'h0, 4'h8, 4'h0, 4'h0, 8'h00, 16'h1100, 2'b00, 4'h8}, // R9
    '{4'h0, 4'h0, 4'h1, 4'h1, 4'h0, 8'h00, 16'h1100, 2'b00, 4'h0}, // R8 set+clr
    '{4'h0, 4'h0, 4'h1, 4'h8, 4'h0, 8'h00, 16'h1100, 2'b00, 4'h1}, // R8 R9
    '{4'h0, 4'h0, 4'h8, 4'h0, 4'h0, 8'h00, 16'h1100, 2'b00, 4'h0}, // R8 clr took
    '{4'h0, 4'h0, 4'h2, 4'h0, 4'h3, 8'h08, 16'h1100, 2'b10, 4'h0}, // R3 R10
    '{4'h2, 4'h0, 4'h0, 4'h2, 4'h0, 8'h08, 16'h1100, 2'b00, 4'h0}, // R8 hazard take wins
    '{4'h0, 4'h0, 4'h0, 4'h2, 4'h1, 8'h00, 16'h1100, 2'b00, 4'h0}  // R3 clear
  };

  task automatic check(input string req, input string what,
                       input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s %s: got %0h expected %0h", req, what, got, exp);
    end
  endtask

  task automatic idle();
    take = '0; give = '0; hset = '0; hclr = '0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    idle();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic print_summary();
    $display("%0d/%0d checks passed", checks - fails, checks);
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000 && !done) begin
      done = 1;
      checks++;
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      print_summary();
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    idle();
    mask = '0;
    do_reset();

    // R1 reset state
    mask = 4'hF;
    #1;
    check("R1", "status", 32'(status), 32'h00);
    check("R1", "free", 32'(free), 32'h3100);
    check("R1", "dispatch", 32'(disp), 32'h0);
    check("R1", "err", 32'(err), 32'h0);

    for (int i = 0; i < 16; i++) begin
      @(negedge clk);
      take = VECS[i].tk; give = VECS[i].gv;
      hset = VECS[i].st; hclr = VECS[i].cl;
      mask = VECS[i].mk;
      #1;
      check("R9", $sformatf("err v%0d", i), 32'(err), 32'(VECS[i].eer));
      @(posedge clk);
      #1;
      idle();
      #0.5;
      check("R4", $sformatf("status v%0d", i), 32'(status), 32'(VECS[i].est));
      check("R5", $sformatf("free v%0d", i), 32'(free), 32'(VECS[i].efr));
      check("R10", $sformatf("dispatch v%0d", i), 32'(disp), 32'(VECS[i].edp));
    end

    // R1 reset taken mid-run: counts restored, hold flags cleared
    do_reset();
    mask = 4'hF;
    #1;
    check("R1", "free after rerun reset", 32'(free), 32'h3100);
    check("R1", "status after rerun reset", 32'(status), 32'h00);
    @(negedge clk);
    hset = 4'h9;
    #1;
    check("R1", "flags cleared by reset", 32'(err), 32'h0);
    @(negedge clk);
    idle();

    // R6 give on a full buffered resource right after reset
    give = 4'h8;
    @(negedge clk);
    idle();
    #1;
    check("R6", "no overflow past size", 32'(free[15:12]), 32'h3);

    // R2 endless resource ignores repeated takes
    take = 4'h1;
    repeat (3) @(negedge clk);
    idle();
    #1;
    check("R2", "endless free", 32'(free[3:0]), 32'h0);
    check("R2", "endless status", 32'(status[1:0]), 32'h0);

    done = 1;
    print_summary();
    $finish;
  end
endmodule